// File: doc/BRIEF.md
# Serial Key-Switch Combination Lock

This block checks a secret code that an operator enters one bit at a time. The operator sets a two-position key switch and paces the entry with a single-cycle confirm strobe. The secret code is not fixed in the logic. It arrives on a parallel input driven by a separate holding register. Digit 0 is compared first, then digit 1, and so on up to the last digit. Once the whole code has been entered, the block raises either an open indication or an alarm indication. It then holds that result until the operator reset is applied.

A wrong digit is never reported on its own. After the first bad digit the controller moves onto a separate failure track that has exactly the same confirm steps as the good track. The alarm appears only after the last digit has been taken. An observer therefore cannot tell which digit was wrong from the timing.

The confirm steps run as follows.
- A first confirm leaves the start state.
- Each digit is sampled on its own confirm.
- Between two digits, one more confirm is needed to move to the next digit.
- No confirm is needed after the last digit.

For the default length of three digits this makes six confirms: start, sample, advance, sample, advance, sample.

Top module: `combo_lock`

## Requirements
- R1: While `rst` is high at a rising clock edge, the lock returns to its start state. After that edge, `unlock` and `error` are both 0.
- R2: When every sampled key bit equals its code bit, `unlock` is 1 starting right after the clock edge on which the final digit is sampled. With the default 3 digits, that is the 6th accepted confirm after reset.
- R3: Digit k, counted from 0, is compared with `comb[k]`. Digit 0 is sampled first and bit 0 of `comb` is the first code bit.
- R4: If any sampled key bit differs from its code bit, `error` is 1 right after the edge on which the final digit is sampled, and `unlock` stays 0.
- R5: Before the final digit is sampled, both `unlock` and `error` stay 0, whether or not an earlier digit was wrong.
- R6: After `unlock` or `error` rises, it stays high and unchanged until reset. Further confirms and key bit changes have no effect on it.
- R7: Asserting `rst` in the middle of an entry discards the partial entry. A complete, correct entry made afterwards still yields `unlock`.
- R8: `unlock` and `error` are never both 1.
- R9: On cycles where `enter` is 0, the controller does not advance, and changes on `key_bit` are ignored.
- R10: Each code bit is read from `comb` on the cycle its digit is sampled. A change to `comb` before a digit is sampled applies to that digit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high operator reset |
| enter | input | 1 | Single-cycle confirm strobe |
| key_bit | input | 1 | Position of the key switch, the bit being entered |
| comb | input | KEY_LEN | Stored secret code; bit k is digit k |
| unlock | output | 1 | Correct code entered |
| error | output | 1 | Wrong code entered; raised only after the last digit |

## Verification
The bench puts a wrong digit at each position in turn and checks that both flags stay low until the final sample. A design that alarms early leaks the position of the bad digit. A design that forgets an early mismatch on the failure track would open the lock.

It uses asymmetric codes to catch a reversed digit order. It also changes `comb` between digits, so a design that latches the whole code at the start would fail. Stray confirms and key toggles are applied after a result, and idle gaps are left between confirms. A design that moves on without a confirm, or that clears or flips a held result, would show it on the outputs.

// File: rtl/combo_lock_pkg.sv
package combo_lock_pkg;

  typedef enum logic [2:0] {
    PH_START = 3'd0,
    PH_COMP  = 3'd1,
    PH_IDLE  = 3'd2,
    PH_OPEN  = 3'd3,
    PH_ALARM = 3'd4
  } lock_phase_e;

  // One entered digit disagrees with its code bit
  function automatic logic bit_differs(input logic want, input logic got);
    return want ^ got;
  endfunction

  // Outcome once the final digit is taken: any miss on the way ends in alarm
  function automatic lock_phase_e final_phase(input logic miss_so_far, input logic miss_now);
    return (miss_so_far | miss_now) ? PH_ALARM : PH_OPEN;
  endfunction

  function automatic logic phase_open(input lock_phase_e ph);
    return ph == PH_OPEN;
  endfunction

  function automatic logic phase_alarm(input lock_phase_e ph);
    return ph == PH_ALARM;
  endfunction

endpackage

// File: rtl/lock_bit_cmp.sv
module lock_bit_cmp
  import combo_lock_pkg::*;
#(
  parameter int KEY_LEN = 3,
  localparam int IDX_W = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1
) (
  input  logic [KEY_LEN-1:0] comb,
  input  logic [IDX_W-1:0]   idx,
  input  logic               key_bit,
  output logic               miss,
  output logic               last_digit
);

  logic want;

  // Code bit is read live, at the cycle of the sample
  always_comb begin
    want = 1'b0;
    for (int k = 0; k < KEY_LEN; k++) begin
      if (idx == IDX_W'(k)) want = comb[k];
    end
  end

  assign miss       = bit_differs(want, key_bit);
  assign last_digit = (idx == IDX_W'(KEY_LEN - 1));

endmodule

// File: rtl/lock_seq_ctrl.sv
module lock_seq_ctrl
  import combo_lock_pkg::*;
#(
  parameter int KEY_LEN = 3,
  localparam int IDX_W = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enter,
  input  logic              miss,
  input  logic              last_digit,
  output lock_phase_e       phase,
  output logic [IDX_W-1:0]  idx,
  output logic              sample_now,
  output logic              sample_last
);

  logic err_track;

  assign sample_now  = enter && (phase == PH_COMP);
  assign sample_last = sample_now && last_digit;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_START;
      idx       <= '0;
      err_track <= 1'b0;
    end else begin
      unique case (phase)
        PH_START: begin
          if (enter) begin
            phase     <= PH_COMP;
            idx       <= '0;
            err_track <= 1'b0;
          end
        end
        PH_COMP: begin
          if (enter) begin
            if (last_digit) begin
              phase <= final_phase(err_track, miss);
            end else begin
              phase     <= PH_IDLE;
              err_track <= err_track | miss;
            end
          end
        end
        PH_IDLE: begin
          if (enter) begin
            phase <= PH_COMP;
            idx   <= idx + IDX_W'(1);
          end
        end
        PH_OPEN, PH_ALARM: begin
          phase <= phase;
        end
        default: phase <= PH_START;
      endcase
    end
  end

endmodule

// File: rtl/lock_out_dec.sv
module lock_out_dec
  import combo_lock_pkg::*;
(
  input  lock_phase_e phase,
  output logic        unlock,
  output logic        error
);

  assign unlock = phase_open(phase);
  assign error  = phase_alarm(phase);

endmodule

// File: rtl/combo_lock.sv
module combo_lock
  import combo_lock_pkg::*;
#(
  parameter int KEY_LEN = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enter,
  input  logic               key_bit,
  input  logic [KEY_LEN-1:0] comb,
  output logic               unlock,
  output logic               error
);

  localparam int IDX_W = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;

  lock_phase_e       phase;
  logic [IDX_W-1:0]  idx;
  logic              miss;
  logic              last_digit;
  logic              sample_now;
  logic              sample_last;

  lock_bit_cmp #(.KEY_LEN(KEY_LEN)) u_cmp (
    .comb       (comb),
    .idx        (idx),
    .key_bit    (key_bit),
    .miss       (miss),
    .last_digit (last_digit)
  );

  lock_seq_ctrl #(.KEY_LEN(KEY_LEN)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .enter       (enter),
    .miss        (miss),
    .last_digit  (last_digit),
    .phase       (phase),
    .idx         (idx),
    .sample_now  (sample_now),
    .sample_last (sample_last)
  );

  lock_out_dec u_dec (
    .phase  (phase),
    .unlock (unlock),
    .error  (error)
  );

endmodule

// File: rtl/combo_lock_chk.sv
module combo_lock_chk
  import combo_lock_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        enter,
  input logic        unlock,
  input logic        error,
  input logic        sample_last,
  input lock_phase_e phase
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!unlock && !error));

  // R8
  no_dual_flag_chk: assert property (@(posedge clk) disable iff (rst) !(unlock && error));

  // R4
  late_alarm_chk: assert property (@(posedge clk) disable iff (rst) $rose(error) |-> $past(sample_last));

  // R2
  late_open_chk: assert property (@(posedge clk) disable iff (rst) $rose(unlock) |-> $past(sample_last));

  // R6
  hold_open_chk: assert property (@(posedge clk) disable iff (rst) unlock |=> unlock);

  // R6
  hold_alarm_chk: assert property (@(posedge clk) disable iff (rst) error |=> error);

  // R9
  no_step_chk: assert property (@(posedge clk) disable iff (rst) !enter |=> $stable(phase));

endmodule

bind combo_lock combo_lock_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .enter       (enter),
  .unlock      (unlock),
  .error       (error),
  .sample_last (sample_last),
  .phase       (phase)
);

// File: tb/combo_lock_bench.sv
module combo_lock_bench;

  localparam int KL = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enter = 1'b0;
  logic          key_bit = 1'b0;
  logic [KL-1:0] comb = '0;
  logic          unlock;
  logic          error;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  combo_lock #(.KEY_LEN(KL)) u_combo_lock (
    .clk     (clk),
    .rst     (rst),
    .enter   (enter),
    .key_bit (key_bit),
    .comb    (comb),
    .unlock  (unlock),
    .error   (error)
  );

  task automatic expect_flags(input string req, input logic exp_u, input logic exp_e);
    n_cmp++;
    if (unlock !== exp_u || error !== exp_e) begin
      n_bad++;
      $display("FAIL %s: unlock/error actual %b%b expected %b%b", req, unlock, error, exp_u, exp_e);
    end
  endtask

  // Drive one confirm with the given key position; returns at the negedge after the edge
  task automatic press(input logic kb);
    @(negedge clk);
    key_bit = kb;
    enter   = 1'b1;
    @(negedge clk);
    enter   = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Full entry; checks flags stay low before the final sample (R5)
  task automatic enter_code(input logic [KL-1:0] bits, input int gap);
    press(1'b0);
    expect_flags("R5", 1'b0, 1'b0);
    for (int k = 0; k < KL; k++) begin
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        key_bit = ~key_bit;
      end
      press(bits[k]);
      if (k < KL - 1) begin
        expect_flags("R5", 1'b0, 1'b0);
        press(~bits[k]);
        expect_flags("R5", 1'b0, 1'b0);
      end
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    expect_flags("R1", 1'b0, 1'b0);
  endtask

  task automatic t_all_codes();
    for (int c = 0; c < (1 << KL); c++) begin
      do_reset();
      comb = KL'(c);
      enter_code(KL'(c), 0);
      expect_flags("R2", 1'b1, 1'b0);
    end
  endtask

  task automatic t_bit_order();
    // comb=3'b110 (bit0=0, bit1=1, bit2=1); entering in reversed order must fail
    do_reset();
    comb = 3'b110;
    enter_code(3'b011, 0);
    expect_flags("R3", 1'b0, 1'b1);
    do_reset();
    enter_code(3'b110, 0);
    expect_flags("R3", 1'b1, 1'b0);
  endtask

  task automatic t_bad_digit();
    for (int p = 0; p < KL; p++) begin
      do_reset();
      comb = 3'b101;
      enter_code(3'b101 ^ KL'(1 << p), 0);
      expect_flags("R4", 1'b0, 1'b1);
    end
    do_reset();
    enter_code(3'b010, 0);
    expect_flags("R4", 1'b0, 1'b1);
  endtask

  task automatic t_hold();
    do_reset();
    comb = 3'b011;
    enter_code(3'b011, 0);
    for (int i = 0; i < 4; i++) begin
      press(i[0]);
      expect_flags("R6", 1'b1, 1'b0);
    end
    do_reset();
    enter_code(3'b111, 0);
    for (int i = 0; i < 4; i++) begin
      press(~i[0]);
      expect_flags("R6", 1'b0, 1'b1);
    end
    do_reset();
    expect_flags("R1", 1'b0, 1'b0);
  endtask

  task automatic t_mid_reset();
    do_reset();
    comb = 3'b100;
    press(1'b0);
    press(1'b1);  // wrong digit 0
    press(1'b0);
    do_reset();
    expect_flags("R7", 1'b0, 1'b0);
    enter_code(3'b100, 0);
    expect_flags("R7", 1'b1, 1'b0);
  endtask

  task automatic t_gaps();
    do_reset();
    comb = 3'b010;
    enter_code(3'b010, 5);
    expect_flags("R9", 1'b1, 1'b0);
    // stop just before the last sample, idle with key toggling: no result yet
    do_reset();
    press(1'b0);
    press(1'b0); press(1'b0);
    press(1'b1); press(1'b0);
    for (int g = 0; g < 6; g++) begin
      @(negedge clk);
      key_bit = ~key_bit;
      expect_flags("R9", 1'b0, 1'b0);
    end
    press(1'b0);
    expect_flags("R9", 1'b1, 1'b0);
  endtask

  task automatic t_live_code();
    do_reset();
    comb = 3'b000;
    press(1'b0);
    press(1'b0);          // digit 0 against comb[0]=0
    press(1'b0);
    comb = 3'b110;        // digits 1,2 now expect 1
    press(1'b1);
    press(1'b0);
    press(1'b1);
    expect_flags("R10", 1'b1, 1'b0);
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_all_codes();
    t_bit_order();
    t_bad_digit();
    t_hold();
    t_mid_reset();
    t_gaps();
    t_live_code();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule